// File: doc/BRIEF.md
# External memory wait-state controller

This block turns single-word read and write requests from the chip's internal fabric into accesses on an asynchronous parallel bus shared by flash and SRAM devices. Three devices hang off the bus, each with its own active-low select line. Each select has a programmable wait count of up to 31. Software sets that count as the device access time divided by one wait-state period, rounded up. At a 6.7 ns wait state the longest usable access is 207 ns. The 23-bit word address reaches 128 Mb of 16-bit storage.

The block holds address, select, read strobe and write strobe steady for the whole access. It captures read data on the final cycle of the access and then raises a one-cycle completion pulse. A mode input picks the normal or the low-power time base. In low-power mode every wait state lasts `LP_DIV` clock cycles, eight by default, which matches the ratio of a 53.57 ns to a 6.7 ns wait state. This lets slow devices, up to about 1660 ns, be served from the same count range.

Top module: `xmem_wait_ctrl`

## Requirements
- R1: After reset all of `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `busy` and `done` are low and `rd_data` is zero.
- R2: A request is accepted at a rising edge where `req_valid` is high, `busy` is low and `req_cs` is 0, 1 or 2. In the next cycle `busy` is high, only bit `req_cs` of `mem_cs_n` is low, and `mem_addr` equals `req_addr`.
- R3: For a read (`req_write`=0) `mem_oe_n` is low and `mem_we_n` high during the access. For a write, `mem_we_n` is low, `mem_oe_n` is high, `mem_dq_oe` is high and `mem_dq_out` equals `req_wdata`. The two strobes are never low together.
- R4: In normal mode (`lp_mode`=0) the strobes stay active for W+1 cycles. W is `cfg_wait[5*c +: 5]` for select c. W=0 gives a one-cycle access.
- R5: In low-power mode (`lp_mode`=1) the strobes stay active for (W+1)*`LP_DIV` cycles.
- R6: The mode and wait count are taken when the request is accepted. Changing `lp_mode` or `cfg_wait` during an access does not alter its length.
- R7: Read data on `mem_dq_in` is captured at the edge that ends the access. `done` is high for exactly the one cycle after the strobes release, and `rd_data` shows the captured word from that cycle on. A write leaves `rd_data` unchanged.
- R8: While `busy` is high, `req_valid` is ignored: select, address and strobes stay unchanged and no extra access follows.
- R9: A request with `req_cs`=3 is ignored: `busy` stays low and all selects stay high.
- R10: `busy` is low in the `done` cycle, so a request still held high then starts a new access in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_mode | input | 1 | 1 = low-power time base (LP_DIV cycles per wait state) |
| cfg_wait | input | 15 | Wait count per select, 5 bits each, select c at bits 5c+4..5c |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Target select index |
| req_addr | input | 23 | Word address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress, requests held off |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last captured read word |
| mem_addr | output | 23 | External address |
| mem_cs_n | output | 3 | Active-low selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 16 | Write data to the bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Read data from the bus |

## Verification
Select, strobes, address and `busy` follow one cycle after the accepting edge. The strobes then hold for N cycles, where N is W+1 or (W+1)*LP_DIV. `done` and the new `rd_data` are due N+1 cycles after acceptance, and `done` is gone at N+2. The bench drives inputs and samples outputs on the falling clock edge. It counts the falling edges where `busy` is high and compares that count, the pulse and the captured word with values computed from the wait count and mode latched at issue. It checks a rejected or ignored request on the falling edge right after the edge that would have taken it.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
   typedef enum logic {
      XM_READ  = 1'b0,
      XM_WRITE = 1'b1
   } xm_dir_e;
endpackage

// File: rtl/xmem_cs_decode.sv
module xmem_cs_decode #(
   parameter int NUM_CS = 3,
   parameter int IDX_W  = 2
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic              en,
   output logic [NUM_CS-1:0] sel_n,
   output logic              idx_ok
);
   assign idx_ok = ({1'b0, idx} < (IDX_W+1)'(NUM_CS));

   for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
      assign sel_n[g] = !(en && (idx == IDX_W'(g)));
   end
endmodule

// File: rtl/xmem_wait_select.sv
module xmem_wait_select #(
   parameter int NUM_CS = 3,
   parameter int IDX_W  = 2,
   parameter int WAIT_W = 5
) (
   input  logic [NUM_CS*WAIT_W-1:0] cfg,
   input  logic [IDX_W-1:0]         idx,
   output logic [WAIT_W-1:0]        wait_val
);
   always_comb begin
      wait_val = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (idx == IDX_W'(i)) wait_val = cfg[i*WAIT_W +: WAIT_W];
      end
   end
endmodule

// File: rtl/xmem_wait_timer.sv
module xmem_wait_timer #(
   parameter int WAIT_W = 5,
   parameter int LP_DIV = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WAIT_W-1:0] wait_val,
   input  logic              slow,
   output logic              running,
   output logic              last
);
   localparam int DIV_W = (LP_DIV > 1) ? $clog2(LP_DIV) : 1;

   logic [WAIT_W-1:0] wcnt;
   logic              run;
   logic              tick;

   if (LP_DIV > 1) begin : g_prescale
      logic [DIV_W-1:0] dcnt;
      logic             slow_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dcnt   <= '0;
            slow_q <= 1'b0;
         end else if (start) begin
            slow_q <= slow;
            dcnt   <= slow ? DIV_W'(LP_DIV-1) : '0;
         end else if (run) begin
            if (dcnt != '0)
               dcnt <= dcnt - 1'b1;
            else if (wcnt != '0)
               dcnt <= slow_q ? DIV_W'(LP_DIV-1) : '0;
         end
      end
      assign tick = (dcnt == '0);
   end else begin : g_direct
      logic unused_slow;
      assign unused_slow = slow;
      assign tick = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt <= '0;
         run  <= 1'b0;
      end else if (start) begin
         wcnt <= wait_val;
         run  <= 1'b1;
      end else if (run && tick) begin
         if (wcnt != '0) wcnt <= wcnt - 1'b1;
         else            run  <= 1'b0;
      end
   end

   assign running = run;
   assign last    = run && tick && (wcnt == '0);
endmodule

// File: rtl/xmem_wait_ctrl.sv
module xmem_wait_ctrl
   import xmem_pkg::*;
#(
   parameter int ADDR_W = 23,
   parameter int DATA_W = 16,
   parameter int NUM_CS = 3,
   parameter int WAIT_W = 5,
   parameter int LP_DIV = 8,
   localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int CFG_W = NUM_CS * WAIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_mode,
   input  logic [CFG_W-1:0]  cfg_wait,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [IDX_W-1:0]  req_cs,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [NUM_CS-1:0] mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   initial begin
      assert (NUM_CS >= 1) else $error("NUM_CS must be at least 1");
      assert (WAIT_W >= 1) else $error("WAIT_W must be at least 1");
      assert (LP_DIV >= 1) else $error("LP_DIV must be at least 1");
      assert (ADDR_W >= 1 && DATA_W >= 1) else $error("bus widths must be positive");
   end

   logic              active;
   xm_dir_e           acc_dir;
   logic [IDX_W-1:0]  acc_idx;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] acc_wdata;
   logic              done_q;
   logic [DATA_W-1:0] rd_q;

   logic              req_ok;
   logic [NUM_CS-1:0] dec_unused_sel_n;
   logic              acc_unused_ok;
   logic [WAIT_W-1:0] sel_wait;
   logic              t_running;
   logic              t_last;
   logic              accept;

   xmem_cs_decode #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_req_dec (
      .idx    (req_cs),
      .en     (1'b0),
      .sel_n  (dec_unused_sel_n),
      .idx_ok (req_ok)
   );

   xmem_cs_decode #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_bus_dec (
      .idx    (acc_idx),
      .en     (active),
      .sel_n  (mem_cs_n),
      .idx_ok (acc_unused_ok)
   );

   xmem_wait_select #(.NUM_CS(NUM_CS), .IDX_W(IDX_W), .WAIT_W(WAIT_W)) u_wsel (
      .cfg      (cfg_wait),
      .idx      (req_cs),
      .wait_val (sel_wait)
   );

   assign accept = req_valid && !active && req_ok;

   xmem_wait_timer #(.WAIT_W(WAIT_W), .LP_DIV(LP_DIV)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .wait_val (sel_wait),
      .slow     (lp_mode),
      .running  (t_running),
      .last     (t_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         acc_dir   <= XM_READ;
         acc_idx   <= '0;
         acc_addr  <= '0;
         acc_wdata <= '0;
         done_q    <= 1'b0;
         rd_q      <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            active    <= 1'b1;
            acc_dir   <= req_write ? XM_WRITE : XM_READ;
            acc_idx   <= req_cs;
            acc_addr  <= req_addr;
            acc_wdata <= req_wdata;
         end else if (active && t_running && t_last) begin
            active <= 1'b0;
            done_q <= 1'b1;
            if (acc_dir == XM_READ) rd_q <= mem_dq_in;
         end
      end
   end

   assign busy       = active;
   assign done       = done_q;
   assign rd_data    = rd_q;
   assign mem_addr   = acc_addr;
   assign mem_oe_n   = !(active && acc_dir == XM_READ);
   assign mem_we_n   = !(active && acc_dir == XM_WRITE);
   assign mem_dq_oe  = active && acc_dir == XM_WRITE;
   assign mem_dq_out = acc_wdata;
endmodule

// File: rtl/xmem_wait_ctrl_chk.sv
module xmem_wait_ctrl_chk #(
   parameter int NUM_CS = 3,
   parameter int IDX_W  = 2,
   parameter int ADDR_W = 23
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [IDX_W-1:0]  req_cs,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [NUM_CS-1:0] mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n
);
   // R2: never more than one select low
   p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n));

   // R3: strobes exclusive
   p_rw_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   // R3: a strobe is low exactly when a select is low
   p_strobe_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n || !mem_we_n) == ($countones(~mem_cs_n) == 1));

   // R7: completion is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: completion only follows an access
   p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R8: bus stays put while an access runs
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_cs_n) &&
                                 $stable(mem_oe_n) && $stable(mem_we_n)));

   // R9: out-of-range select index is not accepted
   p_bad_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && (int'(req_cs) >= NUM_CS)) |=> !busy);
endmodule

bind xmem_wait_ctrl xmem_wait_ctrl_chk #(
   .NUM_CS (NUM_CS),
   .IDX_W  (IDX_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_cs    (req_cs),
   .busy      (busy),
   .done      (done),
   .mem_addr  (mem_addr),
   .mem_cs_n  (mem_cs_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n)
);

// File: tb/xmem_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module xmem_wait_ctrl_tb_top;
   localparam int LPD = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lp_mode = 1'b0;
   logic [14:0] cfg_wait = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_cs = '0;
   logic [22:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, done;
   logic [15:0] rd_data;
   logic [22:0] mem_addr;
   logic [2:0]  mem_cs_n;
   logic        mem_oe_n, mem_we_n;
   logic [15:0] mem_dq_out;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_in = '0;

   int total = 0;
   int bad   = 0;
   logic [15:0] last_rd = '0;

   always #5 clk = ~clk;

   xmem_wait_ctrl #(.LP_DIV(LPD)) dut_i (
      .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .cfg_wait(cfg_wait),
      .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_cycles(input int w, input bit lp);
      return (w + 1) * (lp ? LPD : 1);
   endfunction

   function automatic logic [2:0] exp_sel(input int cs);
      logic [2:0] e = 3'b111;
      e[cs] = 1'b0;
      return e;
   endfunction

   task automatic run_access(input bit wr, input int cs, input logic [22:0] addr,
                             input logic [15:0] wd, input logic [15:0] rdv, input bit perturb);
      int w   = int'(cfg_wait[cs*5 +: 5]);
      bit lp  = lp_mode;
      int exp = exp_cycles(w, lp);
      int n   = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_cs = 2'(cs);
      req_addr = addr; req_wdata = wd; mem_dq_in = rdv;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R2 busy", busy, 1);
      chk(mem_cs_n == exp_sel(cs), "R2 select", mem_cs_n, exp_sel(cs));
      chk(mem_addr == addr, "R2 address", mem_addr, addr);
      chk(mem_oe_n == wr && mem_we_n == !wr, "R3 strobes", {mem_oe_n, mem_we_n}, {wr, !wr});
      if (wr) chk(mem_dq_oe && mem_dq_out == wd, "R3 write data", mem_dq_out, wd);
      if (perturb) begin
         lp_mode = !lp_mode;
         cfg_wait = 15'h7fff;
         req_valid = 1'b1; req_cs = 2'((cs + 1) % 3); req_addr = ~addr;
         n = 1;
         @(negedge clk);
         req_valid = 1'b0;
         chk(mem_cs_n == exp_sel(cs) && mem_addr == addr, "R8 ignored during busy",
             mem_cs_n, exp_sel(cs));
      end
      while (busy && n < 5000) begin
         n++;
         @(negedge clk);
      end
      if (perturb)   chk(n == exp, "R6 latched length", n, exp);
      else if (lp)   chk(n == exp, "R5 low-power length", n, exp);
      else           chk(n == exp, "R4 normal length", n, exp);
      chk(done == 1'b1, "R7 done pulse", done, 1);
      if (!wr) last_rd = rdv;
      chk(rd_data == last_rd, "R7 read data", rd_data, last_rd);
      chk(mem_cs_n == 3'b111, "R7 select released", mem_cs_n, 3'b111);
      @(negedge clk);
      chk(done == 1'b0, "R7 done width", done, 0);
      chk(busy == 1'b0, "R8 no extra access", busy, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(mem_cs_n == 3'b111 && mem_oe_n && mem_we_n, "R1 bus idle in reset", mem_cs_n, 3'b111);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R1 busy/done idle", {busy, done}, 0);
      chk(rd_data == 16'h0, "R1 rd_data zero", rd_data, 0);
      chk(mem_cs_n == 3'b111 && mem_oe_n && mem_we_n, "R1 strobes idle", {mem_oe_n, mem_we_n}, 3);

      // R4: zero wait on select 0, normal mode
      cfg_wait = {5'd31, 5'd3, 5'd0};
      lp_mode = 1'b0;
      run_access(1'b0, 0, 23'h12345, 16'h0, 16'hA5C3, 1'b0);
      // R3: write on select 1, W=3
      run_access(1'b1, 1, 23'h7fffff, 16'h5A3C, 16'hFFFF, 1'b0);
      // R5: low power, W=31 on select 2
      lp_mode = 1'b1;
      run_access(1'b0, 2, 23'h000001, 16'h0, 16'h1234, 1'b0);
      // R5: low power, W=0
      run_access(1'b0, 0, 23'h2AAAAA, 16'h0, 16'h8001, 1'b0);

      // R9: out-of-range select
      lp_mode = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_cs = 2'd3; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b0, "R9 bad index busy", busy, 0);
      chk(mem_cs_n == 3'b111, "R9 bad index select", mem_cs_n, 3'b111);

      // R6 and R8: change mode/config and request during access
      cfg_wait = {5'd0, 5'd0, 5'd2};
      lp_mode = 1'b0;
      run_access(1'b0, 0, 23'h055555, 16'h0, 16'h0F0F, 1'b1);

      // R10: request held high is taken in the done cycle
      cfg_wait = {5'd0, 5'd1, 5'd0};
      lp_mode = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_cs = 2'd1; req_addr = 23'h000100;
      mem_dq_in = 16'hBEEF;
      repeat (3) @(negedge clk);
      chk(done == 1'b1 && busy == 1'b0, "R10 done cycle not busy", {done, busy}, 2);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1 && mem_cs_n == 3'b101, "R10 back-to-back start", mem_cs_n, 3'b101);
      while (busy) @(negedge clk);
      chk(done == 1'b1 && rd_data == 16'hBEEF, "R10 second read data", rd_data, 16'hBEEF);
      last_rd = 16'hBEEF;
      @(negedge clk);

      // random mix
      for (int i = 0; i < 40; i++) begin
         cfg_wait = 15'($urandom);
         lp_mode  = ($urandom % 4) == 0;
         run_access(1'($urandom), int'($urandom % 3), 23'($urandom),
                    16'($urandom), 16'($urandom), 1'b0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule